// File: doc/BRIEF.md
# Multi-channel DMA control register block

This block is the software-visible control and status store of a 64-channel DMA controller. A processor reaches it through a simple 32-bit bus with a byte address and four byte enables. Writes take effect at the clock edge and reads are combinational from the address. It holds:

- a global control word whose three defined bits steer clock gating and arbitration style;
- per-channel bitmaps for request enable, error-interrupt enable, interrupt request and error, each split across a high word (channels 63..32) and a low word (channels 31..0);
- a read-only view of the hardware request lines;
- one priority byte per channel;
- an error status word that records the first error seen.

The channel engines report completion and faults through per-channel pulses, and they receive start and done-clear pulses from this block. Single-channel bits are changed without read-modify-write. Software writes a channel number into one of eight byte-wide command ports. Interrupt and error words clear the bits written with ones. A single interrupt line combines pending completions with errors whose interrupt is enabled.

Top module: `dmarf_regs`

## Requirements
- R1: After reset every register reads zero: control, error status, all bitmaps and all priority bytes. `irq` is low, and `chan_start` and `chan_done_clr` are zero.
- R2: The request-enable words (0x08 high, 0x0C low) and the error-interrupt-enable words (0x10 high, 0x14 low) are read/write, and only bytes with their enable set are written. Bit n of a high word is channel 32+n. Bit n of a low word is channel n. `req_en` mirrors the request-enable bitmap.
- R3: The command words map their byte lanes as follows, with lane k being bits 8k+7..8k. At 0x18: lane 0 sets request enable, lane 1 clears request enable, lane 2 sets error-interrupt enable, lane 3 clears error-interrupt enable. At 0x1C: lane 0 clears the interrupt request, lane 1 clears the error bit, lane 2 starts the channel, lane 3 clears done. Each lane carries a channel number and changes only that channel's bit.
- R4: A command byte whose value is 64 or above changes nothing. Reads of 0x18 and 0x1C return zero.
- R5: A start command raises `chan_start` for the named channel only, during the single clock cycle after the write. A clear-done command does the same on `chan_done_clr`.
- R6: A pulse on `eng_done[n]` sets interrupt-request bit n. A pulse on `eng_err[n]` sets error bit n. When a clear of the same bit happens in the same cycle, the set wins.
- R7: Writing the interrupt-request words (0x20 high, 0x24 low) or the error words (0x28 high, 0x2C low) clears each bit written as one and leaves bits written as zero unchanged. Writing all ones clears the whole word.
- R8: The error status word (0x04) is read-only. When no error is held and error pulses arrive, it captures the following fields:
  - bit 31: set to 1;
  - bits 13:8: the lowest erroring channel number;
  - bit 15: `eng_err_cause[9]`;
  - bit 14: `eng_err_cause[8]`;
  - bits 7:0: `eng_err_cause[7:0]`;
  - all other bits: zero.

  While error bits remain set, later errors do not change the word.
- R9: The error status word returns to zero one cycle after the error bitmap reads all zero.
- R10: `irq` is high whenever any interrupt-request bit is set, or any error bit is set together with its error-interrupt enable.
- R11: In the control word (0x00), bit 31 (`cfg_clk_gate`), bit 3 (`cfg_rr_group`) and bit 2 (`cfg_rr_chan`) are read/write under their byte enables. All other bits read zero.
- R12: Priority byte n sits at address 0x100+n in lane n mod 4. It is read/write under byte enables and drives `chan_prio[8n+7:8n]`.
- R13: Address 0x30 reads `hw_req[63:32]` and address 0x34 reads `hw_req[31:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wr | input | 1 | Write strobe |
| bus_be | input | 4 | Byte enables, bit k for bits 8k+7..8k |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| eng_done | input | NUM_CH | Per-channel completion pulses |
| eng_err | input | NUM_CH | Per-channel error pulses |
| eng_err_cause | input | 10 | Error cause flags for the pulses in the same cycle |
| hw_req | input | NUM_CH | Hardware request lines, visible for reading |
| chan_start | output | NUM_CH | One-cycle start pulse per channel |
| chan_done_clr | output | NUM_CH | One-cycle done-clear pulse per channel |
| req_en | output | NUM_CH | Request-enable bitmap |
| irq | output | 1 | Combined interrupt |
| cfg_clk_gate | output | 1 | Dynamic clock gating enable |
| cfg_rr_group | output | 1 | Round-robin group arbitration select |
| cfg_rr_chan | output | 1 | Round-robin channel arbitration select |
| chan_prio | output | NUM_CH*8 | Priority bytes, channel n in bits 8n+7..8n |

## Verification
The bench builds the block with its defaults, NUM_CH of 64 and ADDR_W of 9. This puts channel 63 in the top bit of each high word, and makes the command value 64 the first out-of-range number. It also places the last priority byte at 0x13F, the final lane of the last priority word. These settings let the bench check the boundary between high and low words, the rejected command values and the top corner of the priority area. It also covers error capture when several channels fail in the same cycle, and the race between a hardware set and a software clear.

// File: rtl/dmarf_pkg.sv
package dmarf_pkg;
  localparam int unsigned MAX_CH  = 64;
  localparam int unsigned CH_W    = 6;
  localparam int unsigned CAUSE_W = 10;
  localparam int unsigned N_CMD   = 8;

  // byte offsets of the register words
  localparam int unsigned OFS_CTRL    = 'h000;
  localparam int unsigned OFS_ESR     = 'h004;
  localparam int unsigned OFS_REQ_HI  = 'h008;
  localparam int unsigned OFS_REQ_LO  = 'h00C;
  localparam int unsigned OFS_EEI_HI  = 'h010;
  localparam int unsigned OFS_EEI_LO  = 'h014;
  localparam int unsigned OFS_CMD_A   = 'h018;
  localparam int unsigned OFS_CMD_B   = 'h01C;
  localparam int unsigned OFS_INT_HI  = 'h020;
  localparam int unsigned OFS_INT_LO  = 'h024;
  localparam int unsigned OFS_ERR_HI  = 'h028;
  localparam int unsigned OFS_ERR_LO  = 'h02C;
  localparam int unsigned OFS_HRQ_HI  = 'h030;
  localparam int unsigned OFS_HRQ_LO  = 'h034;
  localparam int unsigned OFS_PRIO    = 'h100;

  // command index = 4 * (word after 0x18) + byte lane
  typedef enum int unsigned {
    CMD_REQ_SET  = 0,
    CMD_REQ_CLR  = 1,
    CMD_EEI_SET  = 2,
    CMD_EEI_CLR  = 3,
    CMD_INT_CLR  = 4,
    CMD_ERR_CLR  = 5,
    CMD_START    = 6,
    CMD_DONE_CLR = 7
  } cmd_idx_e;

  // control word bits
  localparam int unsigned CTL_CLKGATE = 31;
  localparam int unsigned CTL_RRGRP   = 3;
  localparam int unsigned CTL_RRCH    = 2;

  // error status word fields
  localparam int unsigned ES_VALID = 31;
  localparam int unsigned ES_GRP   = 15;
  localparam int unsigned ES_CHP   = 14;
  localparam int unsigned ES_CH_LO = 8;
endpackage

// File: rtl/dmarf_cmd_port.sv
module dmarf_cmd_port
  import dmarf_pkg::*;
#(
  parameter int unsigned NUM_CH = 64
) (
  input  logic              fire,
  input  logic [7:0]        chan,
  output logic [MAX_CH-1:0] hot
);
  // one-hot decode of a channel number, values out of range dropped
  always_comb begin
    hot = '0;
    if (fire && (32'(chan) < NUM_CH)) hot[chan[CH_W-1:0]] = 1'b1;
  end
endmodule

// File: rtl/dmarf_bitmap.sv
module dmarf_bitmap
  import dmarf_pkg::*;
#(
  parameter int unsigned NUM_CH     = 64,
  parameter bit          CLR_ON_ONE = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hi,
  input  logic              wr_lo,
  input  logic [3:0]        be,
  input  logic [31:0]       wdata,
  input  logic [NUM_CH-1:0] hw_set,
  input  logic [MAX_CH-1:0] cmd_set,
  input  logic [MAX_CH-1:0] cmd_clr,
  output logic [NUM_CH-1:0] map
);
  logic [NUM_CH-1:0] map_q, map_nxt;
  logic [MAX_CH-1:0] cur64, hw64, bm64, wd64, word_nxt, all_nxt;
  logic              upd;

  always_comb begin
    cur64 = '0;
    cur64[NUM_CH-1:0] = map_q;
    hw64 = '0;
    hw64[NUM_CH-1:0] = hw_set;
    wd64 = {wdata, wdata};
    for (int b = 0; b < 4; b++) begin
      bm64[8*b +: 8]      = {8{wr_lo & be[b]}};
      bm64[32 + 8*b +: 8] = {8{wr_hi & be[b]}};
    end
  end

  generate
    if (CLR_ON_ONE) begin : g_w1c
      always_comb word_nxt = cur64 & ~(bm64 & wd64);
    end else begin : g_rw
      always_comb word_nxt = (cur64 & ~bm64) | (wd64 & bm64);
    end
  endgenerate

  // hardware and command sets take precedence over any clear
  always_comb begin
    all_nxt = (word_nxt & ~cmd_clr) | cmd_set | hw64;
    map_nxt = all_nxt[NUM_CH-1:0];
    upd     = wr_hi | wr_lo | (|cmd_set) | (|cmd_clr) | (|hw_set);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   map_q <= '0;
    else if (upd) map_q <= map_nxt;
  end

  assign map = map_q;

  // R6: a hardware set is never lost
  a_r6_hw_set_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    (|hw_set) |=> ((map_q & $past(hw_set)) == $past(hw_set)));
endmodule

// File: rtl/dmarf_err_status.sv
module dmarf_err_status
  import dmarf_pkg::*;
#(
  parameter int unsigned NUM_CH = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_CH-1:0]  err_pulse,
  input  logic [CAUSE_W-1:0] cause,
  input  logic [NUM_CH-1:0]  err_map,
  output logic [31:0]        esr
);
  logic [31:0]     esr_q, esr_nxt, cap;
  logic [CH_W-1:0] first_ch;
  logic            any_err, map_empty, esr_en;

  always_comb begin
    first_ch = '0;
    for (int i = NUM_CH - 1; i >= 0; i--)
      if (err_pulse[i]) first_ch = CH_W'(i);
    any_err   = |err_pulse;
    map_empty = ~|err_map;
    cap                        = '0;
    cap[ES_VALID]              = 1'b1;
    cap[ES_GRP]                = cause[9];
    cap[ES_CHP]                = cause[8];
    cap[ES_CH_LO +: CH_W]      = first_ch;
    cap[7:0]                   = cause[7:0];
  end

  always_comb begin
    esr_nxt = esr_q;
    if ((!esr_q[ES_VALID] || map_empty) && any_err) esr_nxt = cap;
    else if (map_empty)                             esr_nxt = '0;
    esr_en = any_err | map_empty;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      esr_q <= '0;
    else if (esr_en) esr_q <= esr_nxt;
  end

  assign esr = esr_q;

  // R8: a held error is not overwritten while error bits remain
  a_r8_first_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (esr_q[ES_VALID] && !map_empty) |=> $stable(esr_q));
  // R8: an idle status word captures an arriving error
  a_r8_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (!esr_q[ES_VALID] && any_err) |=> esr_q[ES_VALID]);
  // R9: empty error bitmap with no new error empties the status word
  a_r9_idle_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (map_empty && !any_err) |=> (esr_q == 32'd0));
endmodule

// File: rtl/dmarf_regs.sv
module dmarf_regs
  import dmarf_pkg::*;
#(
  parameter int unsigned NUM_CH = 64,
  parameter int unsigned ADDR_W = 9
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_wr,
  input  logic [3:0]          bus_be,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  input  logic [NUM_CH-1:0]   eng_done,
  input  logic [NUM_CH-1:0]   eng_err,
  input  logic [CAUSE_W-1:0]  eng_err_cause,
  input  logic [NUM_CH-1:0]   hw_req,
  output logic [NUM_CH-1:0]   chan_start,
  output logic [NUM_CH-1:0]   chan_done_clr,
  output logic [NUM_CH-1:0]   req_en,
  output logic                irq,
  output logic                cfg_clk_gate,
  output logic                cfg_rr_group,
  output logic                cfg_rr_chan,
  output logic [NUM_CH*8-1:0] chan_prio
);
  localparam int unsigned WA = ADDR_W - 2;

  // reset: asserted asynchronously, released after two clocks
  logic rst_meta, rst_sync;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  logic [WA-1:0] word;
  logic          unused_addr;
  assign word        = bus_addr[ADDR_W-1:2];
  assign unused_addr = ^bus_addr[1:0];

  function automatic logic hit(input logic [WA-1:0] w, input int unsigned ofs);
    return w == WA'(ofs >> 2);
  endfunction

  // command byte ports
  logic [MAX_CH-1:0] cmd_hot [N_CMD];
  generate
    for (genvar i = 0; i < N_CMD; i++) begin : g_cmd
      logic fire;
      assign fire = bus_wr && bus_be[i % 4] && hit(word, OFS_CMD_A + 4 * (i / 4));
      dmarf_cmd_port #(.NUM_CH(NUM_CH)) cmd_i (
        .fire (fire),
        .chan (bus_wdata[8*(i % 4) +: 8]),
        .hot  (cmd_hot[i])
      );
    end
  endgenerate

  // channel bitmaps
  logic [NUM_CH-1:0] req_map, eei_map, int_map, err_map;
  logic [NUM_CH-1:0] no_hw;
  assign no_hw = '0;

  dmarf_bitmap #(.NUM_CH(NUM_CH), .CLR_ON_ONE(1'b0)) req_i (
    .clk(clk), .rst_n(rst_sync),
    .wr_hi(bus_wr && hit(word, OFS_REQ_HI)), .wr_lo(bus_wr && hit(word, OFS_REQ_LO)),
    .be(bus_be), .wdata(bus_wdata), .hw_set(no_hw),
    .cmd_set(cmd_hot[CMD_REQ_SET]), .cmd_clr(cmd_hot[CMD_REQ_CLR]), .map(req_map)
  );

  dmarf_bitmap #(.NUM_CH(NUM_CH), .CLR_ON_ONE(1'b0)) eei_i (
    .clk(clk), .rst_n(rst_sync),
    .wr_hi(bus_wr && hit(word, OFS_EEI_HI)), .wr_lo(bus_wr && hit(word, OFS_EEI_LO)),
    .be(bus_be), .wdata(bus_wdata), .hw_set(no_hw),
    .cmd_set(cmd_hot[CMD_EEI_SET]), .cmd_clr(cmd_hot[CMD_EEI_CLR]), .map(eei_map)
  );

  dmarf_bitmap #(.NUM_CH(NUM_CH), .CLR_ON_ONE(1'b1)) int_i (
    .clk(clk), .rst_n(rst_sync),
    .wr_hi(bus_wr && hit(word, OFS_INT_HI)), .wr_lo(bus_wr && hit(word, OFS_INT_LO)),
    .be(bus_be), .wdata(bus_wdata), .hw_set(eng_done),
    .cmd_set('0), .cmd_clr(cmd_hot[CMD_INT_CLR]), .map(int_map)
  );

  dmarf_bitmap #(.NUM_CH(NUM_CH), .CLR_ON_ONE(1'b1)) err_i (
    .clk(clk), .rst_n(rst_sync),
    .wr_hi(bus_wr && hit(word, OFS_ERR_HI)), .wr_lo(bus_wr && hit(word, OFS_ERR_LO)),
    .be(bus_be), .wdata(bus_wdata), .hw_set(eng_err),
    .cmd_set('0), .cmd_clr(cmd_hot[CMD_ERR_CLR]), .map(err_map)
  );

  logic [31:0] esr;
  dmarf_err_status #(.NUM_CH(NUM_CH)) esr_i (
    .clk(clk), .rst_n(rst_sync), .err_pulse(eng_err), .cause(eng_err_cause),
    .err_map(err_map), .esr(esr)
  );

  // control word
  logic [2:0] ctrl_q, ctrl_nxt;
  logic       ctrl_wr;
  always_comb begin
    ctrl_wr  = bus_wr && hit(word, OFS_CTRL);
    ctrl_nxt = ctrl_q;
    if (bus_be[CTL_CLKGATE / 8]) ctrl_nxt[2] = bus_wdata[CTL_CLKGATE];
    if (bus_be[CTL_RRGRP / 8])   ctrl_nxt[1] = bus_wdata[CTL_RRGRP];
    if (bus_be[CTL_RRCH / 8])    ctrl_nxt[0] = bus_wdata[CTL_RRCH];
  end
  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync)    ctrl_q <= '0;
    else if (ctrl_wr) ctrl_q <= ctrl_nxt;
  end

  // priority bytes
  logic [7:0]        prio_q [NUM_CH];
  logic [NUM_CH-1:0] prio_wr;
  always_comb begin
    for (int ch = 0; ch < NUM_CH; ch++)
      prio_wr[ch] = bus_wr && bus_be[ch % 4] && hit(word, OFS_PRIO + 4 * (ch / 4));
  end
  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) begin
      for (int ch = 0; ch < NUM_CH; ch++) prio_q[ch] <= '0;
    end else begin
      for (int ch = 0; ch < NUM_CH; ch++)
        if (prio_wr[ch]) prio_q[ch] <= bus_wdata[8*(ch % 4) +: 8];
    end
  end

  // start and done-clear pulses, one cycle after the command write
  logic [NUM_CH-1:0] start_q, start_nxt, dclr_q, dclr_nxt;
  logic              pulse_en;
  always_comb begin
    start_nxt = cmd_hot[CMD_START][NUM_CH-1:0];
    dclr_nxt  = cmd_hot[CMD_DONE_CLR][NUM_CH-1:0];
    pulse_en  = (|start_q) | (|dclr_q) | (|start_nxt) | (|dclr_nxt);
  end
  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) begin
      start_q <= '0;
      dclr_q  <= '0;
    end else if (pulse_en) begin
      start_q <= start_nxt;
      dclr_q  <= dclr_nxt;
    end
  end

  // read path
  logic [MAX_CH-1:0] req64, eei64, int64, err64, hrq64;
  always_comb begin
    req64 = '0; req64[NUM_CH-1:0] = req_map;
    eei64 = '0; eei64[NUM_CH-1:0] = eei_map;
    int64 = '0; int64[NUM_CH-1:0] = int_map;
    err64 = '0; err64[NUM_CH-1:0] = err_map;
    hrq64 = '0; hrq64[NUM_CH-1:0] = hw_req;
    bus_rdata = '0;
    if (hit(word, OFS_CTRL)) begin
      bus_rdata[CTL_CLKGATE] = ctrl_q[2];
      bus_rdata[CTL_RRGRP]   = ctrl_q[1];
      bus_rdata[CTL_RRCH]    = ctrl_q[0];
    end
    if (hit(word, OFS_ESR))    bus_rdata = esr;
    if (hit(word, OFS_REQ_HI)) bus_rdata = req64[63:32];
    if (hit(word, OFS_REQ_LO)) bus_rdata = req64[31:0];
    if (hit(word, OFS_EEI_HI)) bus_rdata = eei64[63:32];
    if (hit(word, OFS_EEI_LO)) bus_rdata = eei64[31:0];
    if (hit(word, OFS_INT_HI)) bus_rdata = int64[63:32];
    if (hit(word, OFS_INT_LO)) bus_rdata = int64[31:0];
    if (hit(word, OFS_ERR_HI)) bus_rdata = err64[63:32];
    if (hit(word, OFS_ERR_LO)) bus_rdata = err64[31:0];
    if (hit(word, OFS_HRQ_HI)) bus_rdata = hrq64[63:32];
    if (hit(word, OFS_HRQ_LO)) bus_rdata = hrq64[31:0];
    for (int ch = 0; ch < NUM_CH; ch++)
      if (hit(word, OFS_PRIO + 4 * (ch / 4))) bus_rdata[8*(ch % 4) +: 8] = prio_q[ch];
  end

  always_comb begin
    for (int ch = 0; ch < NUM_CH; ch++) chan_prio[8*ch +: 8] = prio_q[ch];
  end

  assign irq           = (|int_map) | (|(err_map & eei_map));
  assign chan_start    = start_q;
  assign chan_done_clr = dclr_q;
  assign req_en        = req_map;
  assign cfg_clk_gate  = ctrl_q[2];
  assign cfg_rr_group  = ctrl_q[1];
  assign cfg_rr_chan   = ctrl_q[0];

  // R4: a command never names more than one channel
  a_r4_start_onehot: assert property (@(posedge clk) disable iff (!rst_sync)
    $onehot0(start_q) && $onehot0(dclr_q));
  // R5: start pulses only follow a bus write
  a_r5_start_after_write: assert property (@(posedge clk) disable iff (!rst_sync)
    (|start_q) |-> $past(bus_wr));
  // R10: a completion always raises the interrupt next cycle
  a_r10_done_raises_irq: assert property (@(posedge clk) disable iff (!rst_sync)
    (|eng_done) |=> irq);
endmodule

// File: tb/dmarf_regs_tb.sv
`timescale 1ns/1ps
module dmarf_regs_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [8:0]  bus_addr;
  logic        bus_wr;
  logic [3:0]  bus_be;
  logic [31:0] bus_wdata, bus_rdata;
  logic [63:0] eng_done, eng_err, hw_req, chan_start, chan_done_clr, req_en;
  logic [9:0]  eng_err_cause;
  logic        irq, cfg_clk_gate, cfg_rr_group, cfg_rr_chan;
  logic [511:0] chan_prio;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  dmarf_regs dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_be(bus_be),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .eng_done(eng_done), .eng_err(eng_err),
    .eng_err_cause(eng_err_cause), .hw_req(hw_req), .chan_start(chan_start),
    .chan_done_clr(chan_done_clr), .req_en(req_en), .irq(irq), .cfg_clk_gate(cfg_clk_gate),
    .cfg_rr_group(cfg_rr_group), .cfg_rr_chan(cfg_rr_chan), .chan_prio(chan_prio)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [8:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_be = be; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_be = 4'h0;
  endtask

  task automatic rd(input logic [8:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic rdchk(input string tag, input logic [8:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(tag, {32'd0, d}, {32'd0, exp});
  endtask

  task automatic t_reset;
    rdchk("R1 ctrl", 9'h000, 0);
    rdchk("R1 esr", 9'h004, 0);
    rdchk("R1 req hi", 9'h008, 0);
    rdchk("R1 int lo", 9'h024, 0);
    rdchk("R1 err hi", 9'h028, 0);
    rdchk("R1 prio", 9'h13C, 0);
    chk("R1 irq", {63'd0, irq}, 0);
    chk("R1 start", chan_start, 0);
  endtask

  task automatic t_ctrl;
    wr(9'h000, 32'hFFFF_FFFF, 4'hF);
    rdchk("R11 ctrl all", 9'h000, 32'h8000_000C);
    chk("R11 outs", {61'd0, cfg_clk_gate, cfg_rr_group, cfg_rr_chan}, 64'h7);
    wr(9'h000, 32'h0, 4'h1);
    rdchk("R11 ctrl lane0", 9'h000, 32'h8000_0000);
  endtask

  task automatic t_words;
    wr(9'h00C, 32'hA5A5_A5A5, 4'hF);
    rdchk("R2 req lo", 9'h00C, 32'hA5A5_A5A5);
    wr(9'h008, 32'hFFFF_FFFF, 4'h2);
    rdchk("R2 req hi be", 9'h008, 32'h0000_FF00);
    chk("R2 req_en", req_en, 64'h0000_FF00_A5A5_A5A5);
    wr(9'h014, 32'h0000_0010, 4'hF);
    rdchk("R2 eei lo", 9'h014, 32'h10);
    wr(9'h008, 0, 4'hF);
    wr(9'h00C, 0, 4'hF);
    wr(9'h014, 0, 4'hF);
  endtask

  task automatic t_cmd;
    wr(9'h018, 32'h0000_0028, 4'h1);
    rdchk("R3 set req ch40", 9'h008, 32'h0000_0100);
    wr(9'h018, 32'h0003_0000, 4'h4);
    rdchk("R3 set eei ch3", 9'h014, 32'h8);
    wr(9'h018, 32'h0000_2800, 4'h2);
    rdchk("R3 clr req ch40", 9'h008, 0);
    wr(9'h018, 32'h0000_003F, 4'h1);
    chk("R3 set req ch63", req_en, 64'h8000_0000_0000_0000);
    wr(9'h018, 32'h0000_3F00, 4'h2);
  endtask

  task automatic t_range;
    wr(9'h018, 32'h0000_0040, 4'h1);
    chk("R4 value 64", req_en, 0);
    wr(9'h018, 32'h0000_00FF, 4'h1);
    chk("R4 value 255", req_en, 0);
    wr(9'h01C, 32'h0040_0000, 4'h4);
    chk("R4 start 64", chan_start, 0);
    rdchk("R4 read cmd a", 9'h018, 0);
    rdchk("R4 read cmd b", 9'h01C, 0);
  endtask

  task automatic t_start;
    wr(9'h01C, 32'h003F_0000, 4'h4);
    chk("R5 start ch63", chan_start, 64'h8000_0000_0000_0000);
    @(negedge clk);
    chk("R5 start gone", chan_start, 0);
    wr(9'h01C, 32'h0500_0000, 4'h8);
    chk("R5 done clr ch5", chan_done_clr, 64'h20);
    @(negedge clk);
    chk("R5 done clr gone", chan_done_clr, 0);
  endtask

  task automatic t_done;
    @(negedge clk); eng_done = 64'h80;
    @(negedge clk); eng_done = 0;
    rdchk("R6 done sets int", 9'h024, 32'h80);
    chk("R10 irq int", {63'd0, irq}, 1);
    wr(9'h024, 32'h0, 4'hF);
    rdchk("R7 zero keeps", 9'h024, 32'h80);
    wr(9'h024, 32'h80, 4'hF);
    rdchk("R7 one clears", 9'h024, 0);
    chk("R10 irq low", {63'd0, irq}, 0);
    @(negedge clk); eng_done = 64'h0000_0008_0000_0001;
    @(negedge clk); eng_done = 0;
    wr(9'h01C, 32'h0000_0023, 4'h1);
    rdchk("R3 clr int ch35", 9'h020, 0);
    wr(9'h024, 32'hFFFF_FFFF, 4'hF);
    rdchk("R7 all ones", 9'h024, 0);
    // set and clear of bit 2 in one cycle
    @(negedge clk);
    bus_addr = 9'h024; bus_wdata = 32'h4; bus_be = 4'hF; bus_wr = 1'b1; eng_done = 64'h4;
    @(negedge clk);
    bus_wr = 1'b0; bus_be = 0; eng_done = 0;
    rdchk("R6 set wins", 9'h024, 32'h4);
    wr(9'h024, 32'h4, 4'hF);
  endtask

  task automatic t_err;
    @(negedge clk);
    eng_err = (64'd1 << 9) | (64'd1 << 20); eng_err_cause = 10'b10_0000_0101;
    @(negedge clk); eng_err = 0; eng_err_cause = 0;
    rdchk("R6 err bits", 9'h02C, 32'h0010_0200);
    rdchk("R8 capture", 9'h004, 32'h8000_8905);
    chk("R10 err masked", {63'd0, irq}, 0);
    wr(9'h018, 32'h0009_0000, 4'h4);
    chk("R10 err enabled", {63'd0, irq}, 1);
    @(negedge clk); eng_err = 64'd1 << 50; eng_err_cause = 10'b01_1000_0000;
    @(negedge clk); eng_err = 0; eng_err_cause = 0;
    rdchk("R8 later kept", 9'h004, 32'h8000_8905);
    rdchk("R6 err hi", 9'h028, 32'h0004_0000);
    wr(9'h004, 32'h0, 4'hF);
    rdchk("R8 read only", 9'h004, 32'h8000_8905);
    wr(9'h02C, 32'hFFFF_FFFF, 4'hF);
    rdchk("R9 hi still set", 9'h004, 32'h8000_8905);
    wr(9'h01C, 32'h0000_3200, 4'h2);
    rdchk("R9 map empty", 9'h028, 0);
    rdchk("R9 not yet", 9'h004, 32'h8000_8905);
    @(negedge clk);
    rdchk("R9 cleared", 9'h004, 0);
    chk("R10 irq off", {63'd0, irq}, 0);
  endtask

  task automatic t_prio;
    wr(9'h104, 32'h1122_3344, 4'hF);
    rdchk("R12 prio word", 9'h104, 32'h1122_3344);
    chk("R12 prio ch4", {56'd0, chan_prio[32 +: 8]}, 64'h44);
    wr(9'h13C, 32'h00AA_0000, 4'h4);
    rdchk("R12 prio ch62", 9'h13C, 32'h00AA_0000);
    chk("R12 prio out ch62", {56'd0, chan_prio[496 +: 8]}, 64'hAA);
  endtask

  task automatic t_hwreq;
    @(negedge clk); hw_req = 64'h1234_5678_9ABC_DEF0;
    rdchk("R13 hrq hi", 9'h030, 32'h1234_5678);
    rdchk("R13 hrq lo", 9'h034, 32'h9ABC_DEF0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_addr = 0; bus_wr = 0; bus_be = 0; bus_wdata = 0;
    eng_done = 0; eng_err = 0; eng_err_cause = 0; hw_req = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    t_ctrl;
    t_words;
    t_cmd;
    t_range;
    t_start;
    t_done;
    t_err;
    t_prio;
    t_hwreq;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule